// File: doc/BRIEF.md
# Multi-Channel Camera Lane Aligner

This block collects the parallel words of up to three camera receiver lanes (base, medium and full) and delivers them to a single consumer. Each lane arrives with its own recovered clock, a 28-bit word and a strobe that marks a word as present. The base lane also carries the frame, line and data-valid controls and one spare bit. A two-bit mode input sets how many lanes take part: the base lane alone, base plus medium, or all three.

With alignment switched on, every active lane writes its words into a small dual-clock queue. The queues are read together on the base lane clock. A word set leaves the block only when every active queue holds a word, so the lanes are paired by arrival order. The consumer then sees a single strobe and a single valid for the whole set. An overflow in any queue latches an error flag. When frame-valid falls, all queues are drained so the lanes line up again at the start of the next frame. With alignment switched off, each lane's word and strobe go straight to the outputs without any register. Mode and the alignment switch are treated as quasi-static configuration.

Top module: `cam_lane_aligner`

## Requirements
- R1: While reset is asserted with alignment on, and afterwards until a word set is emitted, every strobe, valid, control output and data lane reads 0 and the error flag is 0.
- R2: Mode 0 enables lane 0 (base) only, mode 1 enables lanes 0 and 1, and modes 2 and 3 enable all three. An inactive lane never raises its strobe or valid bit, shows an all-zero data lane, and has no effect on emission.
- R3: With alignment on, a word set is emitted only when every active lane queue holds a word. The lane words in one set carry the same arrival index, and sets leave in arrival order.
- R4: With alignment on, one combined strobe is shown: all active bits of `out_strb` are equal.
- R5: With alignment on, the combined valid is high only for an emitted set whose base word had data-valid high. `out_fval`, `out_lval`, `out_dval` and `out_spare` show the base word's controls and hold between sets.
- R6: Each lane queue accepts 8 unread words. A further write while it is full is dropped.
- R7: A dropped write sets `ovf_err`, which stays high until reset and is not cleared by a frame-end flush.
- R8: A falling edge of base frame-valid (seen on the base clock, alignment on) discards every word already queued, so the next frame starts with all lanes aligned.
- R9: With alignment off, nothing is queued. The lane words, `out_strb` (lane strobes masked by the mode) and base controls are passed through without registers. Valid is strobe AND base data-valid for lane 0, and strobe for lanes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| lane_clk | input | 3 | Recovered clock per lane; bit 0 is the base clock |
| lane_data | input | 84 | 28-bit word per lane; lane k in bits [28k+27:28k] |
| lane_strb | input | 3 | Word-present strobe per lane |
| base_fval | input | 1 | Base lane frame-valid |
| base_lval | input | 1 | Base lane line-valid |
| base_dval | input | 1 | Base lane data-valid |
| base_spare | input | 1 | Base lane spare control bit |
| mode | input | 2 | Active lane count selector |
| align_en | input | 1 | 1 selects aligned output, 0 selects pass-through |
| out_data | output | 84 | Output word per lane |
| out_strb | output | 3 | Strobe per lane (all equal when aligned) |
| out_valid | output | 3 | Valid per lane (all equal when aligned) |
| out_fval | output | 1 | Frame-valid of the current output |
| out_lval | output | 1 | Line-valid of the current output |
| out_dval | output | 1 | Data-valid of the current output |
| out_spare | output | 1 | Spare bit of the current output |
| ovf_err | output | 1 | Sticky queue overflow flag |

## Verification
The bench skews lanes so that one lane's words arrive long after the others. A design that emitted on a partial set, or paired words by time rather than by order, would give sets with mismatched indices or extra sets. It fills one queue to exactly eight and then nine words. An off-by-one in the full test would flag the error too early or never. It then drops frame-valid and sends a fresh frame: without the drain, stale medium words would pair with new base words. Mode changes check that an ignored lane's strobes and data stay out of both the output and the queues. Pass-through checks confirm that the per-lane strobes and data-valid gating are not merged.

// File: rtl/cam_lane_pkg.sv
package cam_lane_pkg;
  localparam int NCH   = 3;
  localparam int CTL_W = 4;

  typedef enum logic [1:0] {
    LANES_ONE   = 2'd0,
    LANES_TWO   = 2'd1,
    LANES_THREE = 2'd2
  } lane_mode_e;

  function automatic logic [NCH-1:0] lane_mask(input logic [1:0] m);
    case (m)
      LANES_ONE: return 3'b001;
      LANES_TWO: return 3'b011;
      default:   return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/cam_lane_sync.sv
module cam_lane_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cam_lane_fifo.sv
module cam_lane_fifo #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic         rst_n,
  input  logic         wr_clk,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_clk,
  input  logic         rd_en,
  input  logic         flush,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         ovf
);
  localparam int DEPTH = 1 << AW;
  typedef logic [AW:0] ptr_t;

  function automatic ptr_t to_gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(input ptr_t g);
    ptr_t b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // gray value the write pointer holds when it leads the read pointer by DEPTH
  function automatic ptr_t full_mark(input ptr_t g);
    return g ^ {2'b11, {(AW-1){1'b0}}};
  endfunction

  logic [W-1:0] mem [DEPTH];
  ptr_t wbin, wgray, rbin, rgray, rgray_w, wgray_r;
  logic full, ovf_w, wr_ok;

  cam_lane_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
  cam_lane_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));
  cam_lane_sync #(.W(1))    u_ovf (.clk(rd_clk), .rst_n(rst_n), .d(ovf_w), .q(ovf));

  assign full  = (wgray == full_mark(rgray_w));
  assign wr_ok = wr_en && !full;
  assign empty = (rgray == wgray_r);
  assign rd_data = mem[rbin[AW-1:0]];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ovf_w <= 1'b0;
    end else if (wr_en) begin
      if (full) begin
        ovf_w <= 1'b1;
      end else begin
        wbin  <= ptr_t'(wbin + 1'b1);
        wgray <= to_gray(ptr_t'(wbin + 1'b1));
      end
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (flush) begin
      rbin  <= from_gray(wgray_r);
      rgray <= wgray_r;
    end else if (rd_en && !empty) begin
      rbin  <= ptr_t'(rbin + 1'b1);
      rgray <= to_gray(ptr_t'(rbin + 1'b1));
    end
  end
endmodule

// File: rtl/cam_lane_aligner.sv
module cam_lane_aligner
  import cam_lane_pkg::*;
#(
  parameter int DW = 28,
  parameter int AW = 3
) (
  input  logic              rst_n,
  input  logic [NCH-1:0]    lane_clk,
  input  logic [NCH*DW-1:0] lane_data,
  input  logic [NCH-1:0]    lane_strb,
  input  logic              base_fval,
  input  logic              base_lval,
  input  logic              base_dval,
  input  logic              base_spare,
  input  logic [1:0]        mode,
  input  logic              align_en,
  output logic [NCH*DW-1:0] out_data,
  output logic [NCH-1:0]    out_strb,
  output logic [NCH-1:0]    out_valid,
  output logic              out_fval,
  output logic              out_lval,
  output logic              out_dval,
  output logic              out_spare,
  output logic              ovf_err
);
  localparam int CW = DW + CTL_W;

  logic              base_clk;
  logic [NCH-1:0]    act, wr_req, fifo_empty, ovf_seen;
  logic [CW-1:0]     head [NCH];
  logic              fval_q, flush_w, pop_w;
  logic [NCH*DW-1:0] al_data;
  logic              al_strb;
  logic [CTL_W-1:0]  al_ctl;   // {fval, lval, dval, spare}

  assign base_clk = lane_clk[0];
  assign act      = lane_mask(mode);
  assign flush_w  = align_en && fval_q && !base_fval;
  assign pop_w    = align_en && ((~fifo_empty & act) == act);

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    logic [CW-1:0] wdat;
    if (k == 0) begin : g_base
      assign wdat = {base_fval, base_lval, base_dval, base_spare, lane_data[0 +: DW]};
    end else begin : g_side
      assign wdat = {{CTL_W{1'b0}}, lane_data[k*DW +: DW]};
    end
    assign wr_req[k] = lane_strb[k] && act[k] && align_en;

    cam_lane_fifo #(.W(CW), .AW(AW)) u_q (
      .rst_n   (rst_n),
      .wr_clk  (lane_clk[k]),
      .wr_en   (wr_req[k]),
      .wr_data (wdat),
      .rd_clk  (base_clk),
      .rd_en   (pop_w && act[k]),
      .flush   (flush_w),
      .rd_data (head[k]),
      .empty   (fifo_empty[k]),
      .ovf     (ovf_seen[k])
    );
  end

  always_ff @(posedge base_clk or negedge rst_n) begin
    if (!rst_n) begin
      fval_q  <= 1'b0;
      al_data <= '0;
      al_strb <= 1'b0;
      al_ctl  <= '0;
      ovf_err <= 1'b0;
    end else begin
      fval_q  <= base_fval;
      al_strb <= pop_w;
      if (|ovf_seen) ovf_err <= 1'b1;
      if (pop_w) begin
        al_ctl <= head[0][CW-1:DW];
        for (int k = 0; k < NCH; k++)
          al_data[k*DW +: DW] <= act[k] ? head[k][DW-1:0] : '0;
      end
    end
  end

  always_comb begin
    if (align_en) begin
      out_data  = al_data;
      out_strb  = {NCH{al_strb}} & act;
      out_valid = {NCH{al_strb && al_ctl[1]}} & act;
      {out_fval, out_lval, out_dval, out_spare} = al_ctl;
    end else begin
      for (int k = 0; k < NCH; k++)
        out_data[k*DW +: DW] = act[k] ? lane_data[k*DW +: DW] : '0;
      out_strb  = lane_strb & act;
      out_valid = lane_strb & act & {{(NCH-1){1'b1}}, base_dval};
      {out_fval, out_lval, out_dval, out_spare} = {base_fval, base_lval, base_dval, base_spare};
    end
  end
endmodule

// File: rtl/cam_lane_aligner_chk.sv
module cam_lane_aligner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       align_en,
  input logic [1:0] mode,
  input logic [2:0] act,
  input logic [2:0] fifo_empty,
  input logic [2:0] out_strb,
  input logic [2:0] out_valid,
  input logic       out_dval,
  input logic       ovf_err
);
  p_inactive_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (((out_strb | out_valid) & ~act) == 3'b000));

  p_set_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (align_en && $past(align_en) && $stable(mode) && out_strb[0])
      |-> ($past(fifo_empty & act) == 3'b000));

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (align_en && $past(align_en) && $stable(mode))
      |-> (out_strb == ({3{out_strb[0]}} & act)));

  p_valid_needs_dval_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (align_en && out_valid[0]) |-> (out_strb[0] && out_dval));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
endmodule

bind cam_lane_aligner cam_lane_aligner_chk u_chk (
  .clk        (lane_clk[0]),
  .rst_n      (rst_n),
  .align_en   (align_en),
  .mode       (mode),
  .act        (act),
  .fifo_empty (fifo_empty),
  .out_strb   (out_strb),
  .out_valid  (out_valid),
  .out_dval   (out_dval),
  .ovf_err    (ovf_err)
);

// File: tb/sim_cam_lane_aligner.sv
`timescale 1ns/1ps
module sim_cam_lane_aligner;
  logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
  logic rst_n = 1'b0;
  logic [27:0] d0 = '0, d1 = '0, d2 = '0;
  logic [2:0]  strb = '0;
  logic fval = 0, lval = 0, dval = 0, spare = 0;
  logic [1:0] mode = 2'd2;
  logic align_en = 1'b1;
  logic [83:0] out_data;
  logic [2:0]  out_strb, out_valid;
  logic out_fval, out_lval, out_dval, out_spare, ovf_err;

  int checks = 0, fails = 0, rec_n = 0;
  bit done = 0;
  logic [83:0] rec_d [64];
  logic [2:0]  rec_s [64];
  logic [2:0]  rec_v [64];

  initial forever #2 c0 = ~c0;
  initial begin #1.3; forever #2 c1 = ~c1; end
  initial begin #2.6; forever #2 c2 = ~c2; end

  cam_lane_aligner u0 (
    .rst_n(rst_n), .lane_clk({c2, c1, c0}), .lane_data({d2, d1, d0}), .lane_strb(strb),
    .base_fval(fval), .base_lval(lval), .base_dval(dval), .base_spare(spare),
    .mode(mode), .align_en(align_en),
    .out_data(out_data), .out_strb(out_strb), .out_valid(out_valid),
    .out_fval(out_fval), .out_lval(out_lval), .out_dval(out_dval), .out_spare(out_spare),
    .ovf_err(ovf_err)
  );

  always @(negedge c0) begin
    if (rst_n && align_en && (out_strb != 3'b000)) begin
      if (rec_n < 64) begin
        rec_d[rec_n] = out_data;
        rec_s[rec_n] = out_strb;
        rec_v[rec_n] = out_valid;
      end
      rec_n++;
    end
  end

  function automatic logic [27:0] word(input int lane, input int fr, input int idx);
    return {4'(lane), 8'(fr), 16'(idx)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [83:0] act, input logic [83:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int k);
    case (k)
      0: @(negedge c0);
      1: @(negedge c1);
      default: @(negedge c2);
    endcase
  endtask

  task automatic waitb(input int n);
    repeat (n) @(negedge c0);
  endtask

  task automatic push(input int k, input int fr, input int first, input int n, input logic [15:0] dm);
    for (int i = 0; i < n; i++) begin
      tick(k);
      case (k)
        0: begin d0 = word(0, fr, first + i); fval = 1; lval = 1; dval = dm[i]; end
        1: d1 = word(1, fr, first + i);
        default: d2 = word(2, fr, first + i);
      endcase
      strb[k] = 1'b1;
    end
    tick(k);
    strb[k] = 1'b0;
  endtask

  // R3: every recorded set from index start onward must hold matching lane words
  task automatic check_sets(input string req, input int start, input int fr, input int first, input int n, input logic [2:0] lanes);
    for (int i = 0; i < n; i++) begin
      logic [83:0] e;
      e = '0;
      for (int k = 0; k < 3; k++)
        if (lanes[k]) e[k*28 +: 28] = word(k, fr, first + i);
      chk(rec_d[start+i] == e, req, rec_d[start+i], e);
      chk(rec_s[start+i] == lanes, "R4 combined strobe", 84'(rec_s[start+i]), 84'(lanes));
    end
  endtask

  task automatic t_reset;
    #1;
    chk(out_strb == 0 && out_valid == 0, "R1 strobe/valid in reset", 84'({out_strb, out_valid}), 84'(0));
    chk(out_data == 0 && ovf_err == 0, "R1 data/error in reset", out_data, 84'(0));
    waitb(3);
    rst_n = 1'b1;
    waitb(4);
    chk({out_fval, out_lval, out_dval, out_spare, ovf_err} == 0, "R1 controls after reset",
        84'({out_fval, out_lval, out_dval, out_spare, ovf_err}), 84'(0));
  endtask

  task automatic t_full;
    int s;
    s = rec_n; mode = 2'd2;
    fork
      push(0, 1, 0, 5, 16'hffff);
      push(1, 1, 0, 5, 16'hffff);
      push(2, 1, 0, 5, 16'hffff);
    join
    waitb(15);
    chk(rec_n - s == 5, "R3 set count full mode", 84'(rec_n - s), 84'(5));
    check_sets("R3 lanes paired in order", s, 1, 0, 5, 3'b111);
    chk(rec_v[s] == 3'b111, "R5 valid with dval", 84'(rec_v[s]), 84'(7));
  endtask

  task automatic t_skew;
    int s;
    s = rec_n;
    fork
      push(0, 2, 0, 4, 16'hffff);
      push(1, 2, 0, 4, 16'hffff);
    join
    waitb(15);
    chk(rec_n == s, "R3 no emission with an empty lane", 84'(rec_n - s), 84'(0));
    push(2, 2, 0, 4, 16'hffff);
    waitb(15);
    chk(rec_n - s == 4, "R3 emission after late lane", 84'(rec_n - s), 84'(4));
    check_sets("R3 skewed lanes paired", s, 2, 0, 4, 3'b111);
  endtask

  task automatic t_medium;
    int s;
    s = rec_n; mode = 2'd1;
    fork
      push(0, 3, 0, 3, 16'hffff);
      push(1, 3, 0, 3, 16'hffff);
      push(2, 3, 0, 3, 16'hffff);
    join
    waitb(15);
    chk(rec_n - s == 3, "R2 medium set count", 84'(rec_n - s), 84'(3));
    check_sets("R2 lane 2 ignored in mode 1", s, 3, 0, 3, 3'b011);
    mode = 2'd0; s = rec_n;
    push(0, 4, 0, 2, 16'hffff);
    waitb(15);
    chk(rec_n - s == 2, "R2 base-only set count", 84'(rec_n - s), 84'(2));
    check_sets("R2 base-only lanes", s, 4, 0, 2, 3'b001);
    // lane 2 queue must be empty: full mode with fresh words pairs them at index 0
    mode = 2'd2; s = rec_n;
    fork
      push(0, 5, 0, 2, 16'hffff);
      push(1, 5, 0, 2, 16'hffff);
      push(2, 5, 0, 2, 16'hffff);
    join
    waitb(15);
    check_sets("R2 ignored lane left no words", s, 5, 0, 2, 3'b111);
  endtask

  task automatic t_valid;
    int s;
    s = rec_n;
    fork
      push(0, 6, 0, 3, 16'b101);
      push(1, 6, 0, 3, 16'hffff);
      push(2, 6, 0, 3, 16'hffff);
    join
    waitb(15);
    chk(rec_v[s] == 3'b111, "R5 valid set 0", 84'(rec_v[s]), 84'(7));
    chk(rec_v[s+1] == 3'b000 && rec_s[s+1] == 3'b111, "R5 strobe without valid",
        84'({rec_s[s+1], rec_v[s+1]}), 84'(6'b111000));
    chk(rec_v[s+2] == 3'b111, "R5 valid set 2", 84'(rec_v[s+2]), 84'(7));
    chk(out_dval && out_fval && out_lval, "R5 controls held", 84'({out_fval, out_lval, out_dval}), 84'(7));
  endtask

  task automatic t_ovf_flush;
    int s;
    push(1, 7, 0, 8, 16'hffff);
    waitb(10);
    chk(ovf_err == 1'b0, "R6 eight words accepted", 84'(ovf_err), 84'(0));
    push(1, 7, 8, 1, 16'hffff);
    waitb(10);
    chk(ovf_err == 1'b1, "R6 ninth word flagged", 84'(ovf_err), 84'(1));
    @(negedge c0); fval = 1'b0;
    waitb(6);
    chk(ovf_err == 1'b1, "R7 error survives flush", 84'(ovf_err), 84'(1));
    s = rec_n;
    fork
      push(0, 8, 0, 3, 16'hffff);
      push(1, 8, 0, 3, 16'hffff);
      push(2, 8, 0, 3, 16'hffff);
    join
    waitb(15);
    chk(rec_n - s == 3, "R8 sets after frame flush", 84'(rec_n - s), 84'(3));
    check_sets("R8 lanes realigned", s, 8, 0, 3, 3'b111);
    chk(ovf_err == 1'b1, "R7 error still set", 84'(ovf_err), 84'(1));
  endtask

  task automatic t_pass;
    int s;
    logic [83:0] e;
    s = rec_n;
    @(negedge c0);
    align_en = 1'b0; mode = 2'd2;
    d0 = 28'h1111111; d1 = 28'h2222222; d2 = 28'h3333333;
    strb = 3'b101; dval = 1'b0; fval = 1'b1; lval = 1'b0; spare = 1'b1;
    #1;
    e = {28'h3333333, 28'h2222222, 28'h1111111};
    chk(out_data == e, "R9 raw lane data", out_data, e);
    chk(out_strb == 3'b101, "R9 raw strobes", 84'(out_strb), 84'(5));
    chk(out_valid == 3'b100, "R9 per-lane valid", 84'(out_valid), 84'(4));
    chk({out_fval, out_lval, out_dval, out_spare} == 4'b1001, "R9 raw controls",
        84'({out_fval, out_lval, out_dval, out_spare}), 84'(9));
    mode = 2'd1; strb = 3'b111; dval = 1'b1;
    #1;
    chk(out_strb == 3'b011 && out_valid == 3'b011, "R2 pass-through mask",
        84'({out_strb, out_valid}), 84'(6'b011011));
    chk(out_data[83:56] == 28'h0, "R2 pass-through lane 2 zero", 84'(out_data[83:56]), 84'(0));
    waitb(4);
    strb = 3'b000;
    mode = 2'd2;
    waitb(2);
    align_en = 1'b1;
    waitb(12);
    chk(rec_n == s, "R9 nothing queued while off", 84'(rec_n - s), 84'(0));
  endtask

  initial begin
    t_reset();
    t_full();
    t_skew();
    t_medium();
    t_valid();
    t_ovf_flush();
    t_pass();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule